// File: doc/BRIEF.md
# Terminal Controller Command Register

This block is the command register of a character display terminal controller. A host writes one bit at a time: it places a 4-bit bit address and a data bit on the inputs and raises a single-cycle write enable. Addresses 8 through E are decoded. Some of these addresses are persistent flags: self-test mode, cursor blink, keyboard interrupt enable, dual-intensity enable and display enable. The other addresses only cause an action. One issues a refresh-memory write strobe. Another steps the cursor one cell forward or back.

The block keeps the cursor address. The host can also load that address directly through a parallel load port. The block divides the clock down to a cursor blink with a 50% duty cycle. It holds a keyboard-ready flag and masks the terminal interrupt with the enable bit. It gates the pixel video with the display enable, and it always passes the sync signals through.

Refresh memory, the character generator, the UART and raster timing are outside the block. They connect only through the strobe, the enables and the cursor address.

Top module: `term_cmd_reg`

## Requirements
- R1: A write to address 8 raises `wr_strobe_o` for exactly one cycle, in the cycle after the write. The data bit has no effect on this. The cursor address does not change, so the strobe is seen together with the unchanged current cursor address.
- R2: A write to address A steps the cursor, and the new address is visible in the cycle after the write. Data 0 adds one to the address and data 1 subtracts one.
- R3: Cursor steps wrap modulo `SCREEN_CELLS`. Stepping forward from `SCREEN_CELLS-1` gives 0, and stepping back from 0 gives `SCREEN_CELLS-1`.
- R4: `cur_load_i` loads `cur_load_addr_i` into the cursor on the next cycle. A load wins over a step write in the same cycle. A load value of `SCREEN_CELLS` or more is ignored.
- R5: Address B sets the blink enable. While it is 1, `cursor_o` is `cursor_show_i` for `BLINK_HALF` cycles and then 0 for `BLINK_HALF` cycles, and this repeats. The first on-interval begins in the cycle after the enabling write. While the blink enable is 0, `cursor_o` equals `cursor_show_i`.
- R6: The keyboard-ready flag sets on `kbd_latch_i` and clears on `kbd_ack_i`. A latch wins when both are high in the same cycle. Address C sets the interrupt enable, and `kbd_int_o` is the flag AND the enable.
- R7: Address E sets the display enable. `video_o` is `pix_video_i` AND the display enable. `hsync_o` and `vsync_o` always equal `hsync_i` and `vsync_i`.
- R8: Address D sets the dual-intensity enable. `mem_attr_o` is `wr_attr_i` AND that enable.
- R9: Address 9 sets `test_mode_o` to the written data bit.
- R10: Reset clears every flag, the cursor address, the strobe and the keyboard-ready flag to 0.
- R11: A write to address 0 through 7 or F changes no flag, the cursor and the strobe. The same holds when the bit address and data change while `bit_we_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_we_i | input | 1 | Single-cycle bit write enable |
| bit_addr_i | input | 4 | Bit address |
| bit_data_i | input | 1 | Bit data |
| cur_load_i | input | 1 | Parallel cursor load |
| cur_load_addr_i | input | ADDR_W | Cursor load value |
| kbd_latch_i | input | 1 | Keyboard data latched pulse |
| kbd_ack_i | input | 1 | Host keyboard acknowledge |
| cursor_show_i | input | 1 | Cursor display enable at this raster position |
| pix_video_i | input | 1 | Character video in |
| hsync_i | input | 1 | Horizontal sync in |
| vsync_i | input | 1 | Vertical sync in |
| wr_attr_i | input | 1 | Pending dual-intensity attribute |
| wr_strobe_o | output | 1 | Refresh memory write strobe |
| cursor_addr_o | output | ADDR_W | Cursor address |
| test_mode_o | output | 1 | Self-test mode |
| mem_attr_o | output | 1 | Attribute after dual-intensity gating |
| kbd_int_o | output | 1 | Terminal interrupt |
| cursor_o | output | 1 | Cursor video after blinking |
| video_o | output | 1 | Blanked video out |
| hsync_o | output | 1 | Horizontal sync out |
| vsync_o | output | 1 | Vertical sync out |

## Verification
The cursor wrap at both ends of the screen is hard to reach with steps alone, because it takes close to two thousand writes. The bench therefore places the cursor at the last cell and at cell 0 with the parallel load, then steps across the edge. The blink phase changes only after a long division. The bench sets a small `BLINK_HALF` and samples exactly at the on/off boundaries, counting from the cycle of the enabling write. It also makes a load and a step land in the same cycle, and a keyboard latch and acknowledge land in the same cycle.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  localparam logic [3:0] CMD_WSTB  = 4'h8;
  localparam logic [3:0] CMD_TEST  = 4'h9;
  localparam logic [3:0] CMD_STEP  = 4'hA;
  localparam logic [3:0] CMD_BLINK = 4'hB;
  localparam logic [3:0] CMD_KIE   = 4'hC;
  localparam logic [3:0] CMD_DUAL  = 4'hD;
  localparam logic [3:0] CMD_DISP  = 4'hE;

  localparam int NUM_FLAGS = 5;
  localparam int FLG_TEST  = 0;
  localparam int FLG_BLINK = 1;
  localparam int FLG_KIE   = 2;
  localparam int FLG_DUAL  = 3;
  localparam int FLG_DISP  = 4;

  localparam logic [3:0] FLAG_ADDR [NUM_FLAGS] =
    '{CMD_TEST, CMD_BLINK, CMD_KIE, CMD_DUAL, CMD_DISP};
endpackage

// File: rtl/tcr_bit_decode.sv
module tcr_bit_decode
  import tcr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bit_we_i,
  input  logic [3:0]           bit_addr_i,
  input  logic                 bit_data_i,
  output logic                 wr_strobe_o,
  output logic                 step_inc_o,
  output logic                 step_dec_o,
  output logic [NUM_FLAGS-1:0] flags_o
);
  logic [NUM_FLAGS-1:0] flags_q;
  logic                 strobe_q;
  logic                 step_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else if (bit_we_i) begin
      for (int f = 0; f < NUM_FLAGS; f++) begin
        if (bit_addr_i == FLAG_ADDR[f]) flags_q[f] <= bit_data_i;
      end
    end
  end

  // data bit is a don't-care for the strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= bit_we_i && (bit_addr_i == CMD_WSTB);
  end

  assign step_hit    = bit_we_i && (bit_addr_i == CMD_STEP);
  assign step_inc_o  = step_hit && !bit_data_i;
  assign step_dec_o  = step_hit &&  bit_data_i;
  assign wr_strobe_o = strobe_q;
  assign flags_o     = flags_q;

  assert_ignore_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_we_i || bit_addr_i < CMD_WSTB || bit_addr_i == 4'hF)
      |=> ($stable(flags_o) && !wr_strobe_o));
endmodule

// File: rtl/tcr_cursor.sv
module tcr_cursor #(
  parameter int ADDR_W       = 11,
  parameter int SCREEN_CELLS = 1920
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              inc_i,
  input  logic              dec_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] LAST_CELL = ADDR_W'(SCREEN_CELLS - 1);
  localparam logic [ADDR_W:0]   CELLS_W   = (ADDR_W+1)'(SCREEN_CELLS);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              load_ok;

  assign load_ok = load_i && ({1'b0, load_addr_i} < CELLS_W);

  always_comb begin
    addr_d = addr_q;
    if (load_ok) begin
      addr_d = load_addr_i;
    end else if (!load_i && inc_i) begin
      addr_d = (addr_q == LAST_CELL) ? '0 : addr_q + 1'b1;
    end else if (!load_i && dec_i) begin
      addr_d = (addr_q == '0) ? LAST_CELL : addr_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  assert_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, addr_o} < CELLS_W);
  assert_wrap_up_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && addr_o == LAST_CELL) |=> (addr_o == '0));
  assert_wrap_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i && addr_o == '0) |=> (addr_o == LAST_CELL));
  assert_load_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && {1'b0, load_addr_i} < CELLS_W) |=> (addr_o == $past(load_addr_i)));
endmodule

// File: rtl/tcr_blink.sv
module tcr_blink #(
  parameter int BLINK_HALF = 62_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic phase_o
);
  localparam int CW = $clog2(BLINK_HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(BLINK_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;

  // held at phase start while disabled, so enabling restarts the on-interval
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else if (!en_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;

  assert_steady_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> phase_o);
  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/tcr_kbd.sv
module tcr_kbd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic latch_i,
  input  logic ack_i,
  input  logic ie_i,
  output logic int_o
);
  logic ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ready_q <= 1'b0;
    else if (latch_i) ready_q <= 1'b1;
    else if (ack_i)   ready_q <= 1'b0;
  end

  assign int_o = ready_q && ie_i;

  assert_latch_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> ready_q);
  assert_ack_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !latch_i) |=> !ready_q);
endmodule

// File: rtl/term_cmd_reg.sv
module term_cmd_reg
  import tcr_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int SCREEN_CELLS = 1920,
  parameter int BLINK_HALF   = 62_500_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_we_i,
  input  logic [3:0]        bit_addr_i,
  input  logic              bit_data_i,
  input  logic              cur_load_i,
  input  logic [ADDR_W-1:0] cur_load_addr_i,
  input  logic              kbd_latch_i,
  input  logic              kbd_ack_i,
  input  logic              cursor_show_i,
  input  logic              pix_video_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              wr_attr_i,
  output logic              wr_strobe_o,
  output logic [ADDR_W-1:0] cursor_addr_o,
  output logic              test_mode_o,
  output logic              mem_attr_o,
  output logic              kbd_int_o,
  output logic              cursor_o,
  output logic              video_o,
  output logic              hsync_o,
  output logic              vsync_o
);
  logic [NUM_FLAGS-1:0] flags;
  logic                 step_inc, step_dec;
  logic                 blink_phase;

  tcr_bit_decode u_decode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_we_i    (bit_we_i),
    .bit_addr_i  (bit_addr_i),
    .bit_data_i  (bit_data_i),
    .wr_strobe_o (wr_strobe_o),
    .step_inc_o  (step_inc),
    .step_dec_o  (step_dec),
    .flags_o     (flags)
  );

  tcr_cursor #(
    .ADDR_W       (ADDR_W),
    .SCREEN_CELLS (SCREEN_CELLS)
  ) u_cursor (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (cur_load_i),
    .load_addr_i (cur_load_addr_i),
    .inc_i       (step_inc),
    .dec_i       (step_dec),
    .addr_o      (cursor_addr_o)
  );

  tcr_blink #(
    .BLINK_HALF (BLINK_HALF)
  ) u_blink (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (flags[FLG_BLINK]),
    .phase_o (blink_phase)
  );

  tcr_kbd u_kbd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .latch_i (kbd_latch_i),
    .ack_i   (kbd_ack_i),
    .ie_i    (flags[FLG_KIE]),
    .int_o   (kbd_int_o)
  );

  assign test_mode_o = flags[FLG_TEST];
  assign mem_attr_o  = wr_attr_i && flags[FLG_DUAL];
  assign cursor_o    = cursor_show_i && blink_phase;
  // blanking gates video only; sync is never blanked
  assign video_o     = pix_video_i && flags[FLG_DISP];
  assign hsync_o     = hsync_i;
  assign vsync_o     = vsync_i;

  assert_strobe_keeps_cursor_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_we_i && bit_addr_i == CMD_WSTB && !cur_load_i) |=> $stable(cursor_addr_o));
  assert_blank_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_we_i && bit_addr_i == CMD_DISP && !bit_data_i) |=> !video_o);
endmodule

// File: tb/term_cmd_reg_tb.sv
`timescale 1ns/1ps
module term_cmd_reg_tb;
  localparam int AW    = 11;
  localparam int CELLS = 1920;
  localparam int HALF  = 4;
  localparam int NV    = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 0, data = 0, load = 0, latch = 0, ack = 0;
  logic show = 0, pix = 0, hs = 0, vs = 0, attr = 0;
  logic [3:0] addr = '0;
  logic [AW-1:0] load_addr = '0;
  logic strobe, test_mode, mattr, kint, cur, vid, hso, vso;
  logic [AW-1:0] caddr;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  term_cmd_reg #(.ADDR_W(AW), .SCREEN_CELLS(CELLS), .BLINK_HALF(HALF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_we_i(we), .bit_addr_i(addr), .bit_data_i(data),
    .cur_load_i(load), .cur_load_addr_i(load_addr), .kbd_latch_i(latch), .kbd_ack_i(ack),
    .cursor_show_i(show), .pix_video_i(pix), .hsync_i(hs), .vsync_i(vs), .wr_attr_i(attr),
    .wr_strobe_o(strobe), .cursor_addr_o(caddr), .test_mode_o(test_mode), .mem_attr_o(mattr),
    .kbd_int_o(kint), .cursor_o(cur), .video_o(vid), .hsync_o(hso), .vsync_o(vso));

  // {addr, data, exp cursor, exp test, exp disp, exp kie, exp dual}
  localparam logic [19:0] VEC [NV] = '{
    {4'hA, 1'b0, 11'd6, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'hA, 1'b0, 11'd7, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'hA, 1'b1, 11'd6, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'h9, 1'b1, 11'd6, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'hE, 1'b1, 11'd6, 1'b1, 1'b1, 1'b0, 1'b0},
    {4'hC, 1'b1, 11'd6, 1'b1, 1'b1, 1'b1, 1'b0},
    {4'hD, 1'b1, 11'd6, 1'b1, 1'b1, 1'b1, 1'b1},
    {4'hF, 1'b0, 11'd6, 1'b1, 1'b1, 1'b1, 1'b1},
    {4'h7, 1'b0, 11'd6, 1'b1, 1'b1, 1'b1, 1'b1},
    {4'h9, 1'b0, 11'd6, 1'b0, 1'b1, 1'b1, 1'b1},
    {4'hE, 1'b0, 11'd6, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'hC, 1'b0, 11'd6, 1'b0, 1'b0, 1'b0, 1'b1},
    {4'hA, 1'b1, 11'd5, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bit_write(input logic [3:0] a, input logic d);
    @(negedge clk); we = 1; addr = a; data = d;
    @(negedge clk); we = 0; addr = 4'h0; data = 0;
  endtask

  task automatic cur_load(input logic [AW-1:0] v);
    @(negedge clk); load = 1; load_addr = v;
    @(negedge clk); load = 0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    show = 1; pix = 1; attr = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check("R10 cursor", caddr, 0);
    check("R10 strobe", strobe, 0);
    check("R10 test", test_mode, 0);
    check("R10 video blank", vid, 0);
    check("R10 dual off", mattr, 0);
    check("R10 steady cursor", cur, 1);
    // R7 sync passes while blanked
    hs = 1; vs = 0; #0.5;
    check("R7 hsync", hso, 1);
    check("R7 vsync", vso, 0);
    hs = 0; vs = 1; #0.5;
    check("R7 hsync low", hso, 0);
    check("R7 vsync high", vso, 1);
    // R10 kint masked after reset with flag set
    @(negedge clk); latch = 1; @(negedge clk); latch = 0;
    check("R10 kint masked", kint, 0);

    cur_load(11'd5);
    check("R4 load", caddr, 5);
    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      v = VEC[i];
      bit_write(v[19:16], v[15]);
      check($sformatf("R2 vec%0d cursor", i), caddr, v[14:4]);
      check($sformatf("R9 vec%0d test", i), test_mode, v[3]);
      check($sformatf("R7 vec%0d video", i), vid, v[2]);
      check($sformatf("R6 vec%0d kint", i), kint, v[1]);
      check($sformatf("R8 vec%0d attr", i), mattr, v[0]);
    end

    // R1 strobe with both data values
    cur_load(11'd100);
    bit_write(4'h8, 1'b1);
    check("R1 strobe high", strobe, 1);
    check("R1 cursor at strobe", caddr, 100);
    @(negedge clk);
    check("R1 strobe one cycle", strobe, 0);
    bit_write(4'h8, 1'b0);
    check("R1 strobe data0", strobe, 1);
    check("R1 cursor kept", caddr, 100);

    // R3 wrap
    cur_load(11'(CELLS - 1));
    bit_write(4'hA, 1'b0);
    check("R3 wrap up", caddr, 0);
    bit_write(4'hA, 1'b1);
    check("R3 wrap down", caddr, CELLS - 1);

    // R4 load priority and out-of-range load
    @(negedge clk); load = 1; load_addr = 11'd50; we = 1; addr = 4'hA; data = 0;
    @(negedge clk); load = 0; we = 0; addr = 0;
    check("R4 load beats step", caddr, 50);
    cur_load(11'd2000);
    check("R4 oversize load ignored", caddr, 50);

    // R11 disabled write
    @(negedge clk); we = 0; addr = 4'h9; data = 1;
    @(negedge clk); addr = 0; data = 0;
    check("R11 no we", test_mode, 0);
    bit_write(4'hF, 1'b1);
    check("R11 addr F cursor", caddr, 50);
    check("R11 addr F strobe", strobe, 0);

    // R6 keyboard flag
    bit_write(4'hC, 1'b1);
    check("R6 ready from before", kint, 1);
    @(negedge clk); ack = 1; @(negedge clk); ack = 0;
    check("R6 ack clears", kint, 0);
    @(negedge clk); latch = 1; ack = 1; @(negedge clk); latch = 0; ack = 0;
    check("R6 latch wins", kint, 1);

    // R5 blink
    bit_write(4'hB, 1'b1);
    for (int k = 0; k < 12; k++) begin
      if (k == 3)  check("R5 on end", cur, 1);
      if (k == 4)  check("R5 off start", cur, 0);
      if (k == 7)  check("R5 off end", cur, 0);
      if (k == 8)  check("R5 on again", cur, 1);
      @(negedge clk);
    end
    show = 0; #0.5;
    check("R5 show gate", cur, 0);
    show = 1;
    bit_write(4'hB, 1'b0);
    repeat (5) begin
      @(negedge clk);
      check("R5 steady", cur, 1);
    end

    // R10 reset mid-run
    bit_write(4'h9, 1'b1);
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    check("R10 test cleared", test_mode, 0);
    check("R10 cursor cleared", caddr, 0);
    check("R10 kint cleared", kint, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule